// File: doc/BRIEF.md
# Fast Page DRAM Access Controller

This block sits between a simple host port and an asynchronous dynamic RAM that has a multiplexed address bus and fast page mode. A host request carries a 24-bit word address, a write flag and 4 bits of write data, and it is taken on a valid/ready handshake. Address bits [23:11] are the row and bits [10:0] are the column. The controller opens a row by pulling RAS low and then leaves it open. Each later request that hits the same row costs only one column cycle on CAS.

The row is closed, and RAS is returned high for a precharge, in three cases: a request arrives for a different row, the row has been open for close to the maximum RAS-low time, or the refresh sequencer raises its request. A refresh request lets the current column cycle finish and then precharges the row. The controller then grants the DRAM bus and takes no host request until the refresh request drops. Writes use early-write timing (WE falls before CAS), so the memory never drives its data pins during a write. Reads return the sampled nibble on a one-cycle response pulse.

Every analog limit is a nanosecond figure that is turned into a whole number of clock cycles from the clock period parameter, rounding up.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: After reset, RAS, CAS, WE and OE are high, the controller does not drive the data pins, the refresh grant and the response are low, and req_ready is high.
- R2: Opening a row places the row address (host bits [23:11], 13 bits) on the address pins as RAS falls and holds it for at least 10 ns. The column (host bits [10:0]) then appears on address pins [10:0], with pins [12:11] at zero, and CAS falls no sooner than 20 ns after RAS.
- R3: A read samples the data pins when at least 60 ns have passed since RAS fell, 15 ns since CAS fell and 30 ns since the column address changed. The nibble is returned on rsp_rdata with rsp_valid high for exactly one cycle.
- R4: A request to the open row is served with a CAS-only column cycle, and RAS stays low.
- R5: A request to a different row closes the open row and keeps RAS high for at least 40 ns before it opens the new row.
- R6: In a write, WE is low before CAS falls and OE stays high. The controller drives the write data for the whole time CAS is low, and the memory's output is never enabled while the controller drives.
- R7: In page mode, CAS stays low for at least 15 ns and high for at least 10 ns, CAS falls are at least 40 ns apart, and the column address does not change while CAS is low.
- R8: RAS never stays low longer than RAS_MAX_NS, even when page hits continue without a gap.
- R9: On a refresh request the controller finishes the column cycle in progress, raises RAS, and asserts ref_gnt. While the grant is held, RAS and CAS stay high and req_ready stays low. After the request is released, RAS stays high for at least 40 ns before the next row opens.
- R10: Successive RAS falls are at least 110 ns apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Word address: [23:11] row, [10:0] column |
| req_wdata | input | 4 | Write data |
| rsp_valid | output | 1 | One-cycle read response strobe |
| rsp_rdata | output | 4 | Read data |
| ref_req | input | 1 | Refresh sequencer wants the bus |
| ref_gnt | output | 1 | Bus handed to the refresh sequencer |
| dram_addr | output | 13 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_o | output | 4 | Data driven to the memory |
| dram_dq_oe | output | 1 | Controller drives the data pins |
| dram_dq_i | input | 4 | Data from the memory |

## Verification
The bench builds the block with CLK_NS = 20 and RAS_MAX_NS = 1000. At this clock period the derived counts are one cycle for the row-to-column delay, one cycle of column setup, one cycle of CAS low and three cycles of precharge. The first read of a row therefore samples exactly 60 ns after RAS falls, which puts the access-time boundary within reach. The shortened RAS limit forces a row close after about fifty cycles of continuous page hits. A behavioural memory model in the bench returns inverted data whenever it is sampled before its access times have all passed.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  // Memory timing limits in nanoseconds
  localparam int NS_RCD  = 20;   // RAS fall to CAS fall, minimum
  localparam int NS_RAH  = 10;   // row address hold after RAS fall
  localparam int NS_RAC  = 60;   // access from RAS
  localparam int NS_CAC  = 15;   // access from CAS
  localparam int NS_AA   = 30;   // access from column address
  localparam int NS_CASW = 15;   // CAS low width
  localparam int NS_CP   = 10;   // CAS high width in page mode
  localparam int NS_PC   = 40;   // page column cycle
  localparam int NS_RP   = 40;   // RAS precharge
  localparam int NS_RC   = 110;  // random cycle
  localparam int NS_DH   = 10;   // data / column hold after CAS fall

  typedef enum logic [2:0] {
    ST_IDLE, ST_RCD, ST_COL, ST_CASL, ST_OPEN, ST_PRE, ST_GNT
  } seq_st_t;

  function automatic int cyc(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/fpm_row_track.sv
module fpm_row_track #(
  parameter int ROW_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             clr,
  input  logic [ROW_W-1:0] load_row,
  input  logic [ROW_W-1:0] cmp_row,
  output logic [ROW_W-1:0] open_row,
  output logic             hit
);
  logic             vld_q;
  logic [ROW_W-1:0] row_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      row_q <= '0;
    end else if (load) begin
      vld_q <= 1'b1;
      row_q <= load_row;
    end else if (clr) begin
      vld_q <= 1'b0;
    end
  end

  assign open_row = row_q;
  assign hit      = vld_q && (cmp_row == row_q);
endmodule

// File: rtl/fpm_open_timer.sv
module fpm_open_timer #(
  parameter int LIM   = 4000,
  parameter int CNT_W = $clog2(LIM + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic row_open,
  output logic expired
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!row_open)                cnt_d = '0;
    else if (cnt_q != CNT_W'(LIM)) cnt_d = cnt_q + 1'b1;
    else                          cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == CNT_W'(LIM));
endmodule

// File: rtl/fpm_seq.sv
module fpm_seq
  import fpm_pkg::*;
#(
  parameter int COL_W  = 11,
  parameter int DATA_W = 4,
  parameter int C_RCD  = 1,
  parameter int C_COL  = 1,
  parameter int C_CASL = 1,
  parameter int C_RP   = 3,
  parameter int DLY_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [COL_W-1:0]  req_col,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              row_hit,
  input  logic              open_expired,
  input  logic              ref_req,
  input  logic [DATA_W-1:0] dq_i,
  output logic              req_ready,
  output logic              load_row,
  output logic              clr_row,
  output logic              row_open,
  output logic              sel_row,
  output logic [COL_W-1:0]  col,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic              oe_n,
  output logic              dq_oe,
  output logic [DATA_W-1:0] dq_o,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              ref_gnt
);
  seq_st_t           st_q, st_d;
  logic [DLY_W-1:0]  dly_q, dly_d;
  logic [COL_W-1:0]  col_q;
  logic              we_q;
  logic [DATA_W-1:0] wd_q, rd_q;
  logic              rv_q;
  logic              acc, sample, xfer;

  always_comb begin
    req_ready = ((st_q == ST_IDLE) && !ref_req) ||
                ((st_q == ST_OPEN) && row_hit && !open_expired && !ref_req);
    acc   = req_valid && req_ready;
    st_d  = st_q;
    dly_d = (dly_q != '0) ? dly_q - 1'b1 : '0;
    case (st_q)
      ST_IDLE: if (ref_req) st_d = ST_GNT;
               else if (acc) begin st_d = ST_RCD; dly_d = DLY_W'(C_RCD - 1); end
      ST_RCD:  if (dly_q == '0) begin st_d = ST_COL; dly_d = DLY_W'(C_COL - 1); end
      ST_COL:  if (dly_q == '0) begin st_d = ST_CASL; dly_d = DLY_W'(C_CASL - 1); end
      ST_CASL: if (dly_q == '0) st_d = ST_OPEN;
      ST_OPEN: if (acc) begin st_d = ST_COL; dly_d = DLY_W'(C_COL - 1); end
               else if (ref_req || open_expired || req_valid) begin
                 st_d = ST_PRE; dly_d = DLY_W'(C_RP - 1);
               end
      ST_PRE:  if (dly_q == '0) st_d = ST_IDLE;
      ST_GNT:  if (!ref_req) begin st_d = ST_PRE; dly_d = DLY_W'(C_RP - 1); end
      default: st_d = ST_IDLE;
    endcase
  end

  assign sample = (st_q == ST_CASL) && (dly_q == '0) && !we_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      dly_q <= '0;
      col_q <= '0;
      we_q  <= 1'b0;
      wd_q  <= '0;
      rv_q  <= 1'b0;
      rd_q  <= '0;
    end else begin
      st_q  <= st_d;
      dly_q <= dly_d;
      rv_q  <= sample;
      if (acc) begin
        col_q <= req_col;
        we_q  <= req_we;
        wd_q  <= req_wdata;
      end
      if (sample) rd_q <= dq_i;
    end
  end

  assign row_open  = (st_q == ST_RCD) || (st_q == ST_COL) ||
                     (st_q == ST_CASL) || (st_q == ST_OPEN);
  assign xfer      = (st_q == ST_COL) || (st_q == ST_CASL);
  assign load_row  = acc && (st_q == ST_IDLE);
  assign clr_row   = (st_q == ST_PRE);
  assign sel_row   = (st_q == ST_RCD);
  assign col       = col_q;
  assign ras_n     = !row_open;
  assign cas_n     = (st_q != ST_CASL);
  assign we_n      = !(xfer && we_q);
  assign oe_n      = !(xfer && !we_q);
  assign dq_oe     = xfer && we_q;
  assign dq_o      = wd_q;
  assign rsp_valid = rv_q;
  assign rsp_rdata = rd_q;
  assign ref_gnt   = (st_q == ST_GNT);
endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl
  import fpm_pkg::*;
#(
  parameter int CLK_NS     = 20,
  parameter int RAS_MAX_NS = 100000,
  parameter int ROW_W      = 13,
  parameter int COL_W      = 11,
  parameter int DATA_W     = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_we,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic [DATA_W-1:0]      req_wdata,
  output logic                   rsp_valid,
  output logic [DATA_W-1:0]      rsp_rdata,
  input  logic                   ref_req,
  output logic                   ref_gnt,
  output logic [ROW_W-1:0]       dram_addr,
  output logic                   dram_ras_n,
  output logic                   dram_cas_n,
  output logic                   dram_we_n,
  output logic                   dram_oe_n,
  output logic [DATA_W-1:0]      dram_dq_o,
  output logic                   dram_dq_oe,
  input  logic [DATA_W-1:0]      dram_dq_i
);
  localparam int C_CASL = imax(imax(cyc(NS_CAC, CLK_NS), cyc(NS_AA, CLK_NS) - 1),
                               imax(imax(cyc(NS_DH, CLK_NS), cyc(NS_CASW, CLK_NS)), 1));
  localparam int C_COL  = imax(imax(1, cyc(NS_CP, CLK_NS)), cyc(NS_PC, CLK_NS) - C_CASL);
  localparam int C_RCD  = imax(imax(cyc(NS_RCD, CLK_NS), cyc(NS_RAH, CLK_NS)),
                               cyc(NS_RAC, CLK_NS) - C_COL - C_CASL);
  localparam int C_RP   = imax(cyc(NS_RP, CLK_NS), cyc(NS_RC, CLK_NS) - C_RCD - C_COL - C_CASL);
  localparam int C_MAXD = imax(imax(C_RCD, C_COL), imax(C_CASL, C_RP));
  localparam int DLY_W  = imax($clog2(C_MAXD + 1), 1);
  localparam int RAS_MAX_CYC = RAS_MAX_NS / CLK_NS;
  localparam int C_OPEN_LIM  = RAS_MAX_CYC - C_COL - C_CASL - 2;

  logic [1:0]       rs_q;
  logic             rst_i_n;
  logic [ROW_W-1:0] open_row;
  logic [COL_W-1:0] col;
  logic             hit, expired, load_row, clr_row, row_open, sel_row;

  // reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  fpm_row_track #(.ROW_W(ROW_W)) u_track (
    .clk(clk), .rst_n(rst_i_n), .load(load_row), .clr(clr_row),
    .load_row(req_addr[ROW_W+COL_W-1:COL_W]), .cmp_row(req_addr[ROW_W+COL_W-1:COL_W]),
    .open_row(open_row), .hit(hit)
  );

  fpm_open_timer #(.LIM(C_OPEN_LIM)) u_timer (
    .clk(clk), .rst_n(rst_i_n), .row_open(row_open), .expired(expired)
  );

  fpm_seq #(
    .COL_W(COL_W), .DATA_W(DATA_W), .C_RCD(C_RCD), .C_COL(C_COL),
    .C_CASL(C_CASL), .C_RP(C_RP), .DLY_W(DLY_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_i_n), .req_valid(req_valid), .req_we(req_we),
    .req_col(req_addr[COL_W-1:0]), .req_wdata(req_wdata), .row_hit(hit),
    .open_expired(expired), .ref_req(ref_req), .dq_i(dram_dq_i),
    .req_ready(req_ready), .load_row(load_row), .clr_row(clr_row),
    .row_open(row_open), .sel_row(sel_row), .col(col),
    .ras_n(dram_ras_n), .cas_n(dram_cas_n), .we_n(dram_we_n), .oe_n(dram_oe_n),
    .dq_oe(dram_dq_oe), .dq_o(dram_dq_o), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .ref_gnt(ref_gnt)
  );

  assign dram_addr = sel_row ? open_row : {{(ROW_W-COL_W){1'b0}}, col};
endmodule

// File: rtl/fpm_dram_ctrl_chk.sv
module fpm_dram_ctrl_chk #(
  parameter int AW          = 13,
  parameter int RAS_MAX_CYC = 5000,
  parameter int C_RP        = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dram_ras_n,
  input logic          dram_cas_n,
  input logic          dram_we_n,
  input logic          dram_oe_n,
  input logic          dram_dq_oe,
  input logic [AW-1:0] dram_addr,
  input logic          ref_gnt,
  input logic          req_ready,
  input logic          rsp_valid
);
  localparam int LW = $clog2(RAS_MAX_CYC + 2);
  logic [LW-1:0] lowrun;
  logic [7:0]    hirun;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lowrun <= '0;
      hirun  <= 8'(C_RP);
    end else begin
      if (dram_ras_n) lowrun <= '0;
      else if (lowrun <= LW'(RAS_MAX_CYC)) lowrun <= lowrun + 1'b1;
      if (!dram_ras_n) hirun <= '0;
      else if (hirun < 8'(C_RP)) hirun <= hirun + 1'b1;
    end
  end

  AST_CAS_INSIDE_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_cas_n |-> !dram_ras_n);                                     // R2
  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);                                        // R3
  AST_PRECHARGE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) |-> (hirun >= 8'(C_RP)));                       // R5
  AST_WE_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_cas_n) |-> $stable(dram_we_n));                        // R6
  AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_oe_n |-> !dram_dq_oe);                                      // R6
  AST_COL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!dram_cas_n && $past(!dram_cas_n)) |-> $stable(dram_addr));      // R7
  AST_RAS_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    lowrun <= LW'(RAS_MAX_CYC));                                      // R8
  AST_GRANT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ref_gnt |-> (dram_ras_n && dram_cas_n && !req_ready));            // R9
endmodule

bind fpm_dram_ctrl fpm_dram_ctrl_chk #(
  .AW(ROW_W), .RAS_MAX_CYC(RAS_MAX_CYC), .C_RP(C_RP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
  .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n), .dram_dq_oe(dram_dq_oe),
  .dram_addr(dram_addr), .ref_gnt(ref_gnt), .req_ready(req_ready),
  .rsp_valid(rsp_valid)
);

// File: tb/test_fpm_dram_ctrl.sv
`timescale 1ns/1ps
module test_fpm_dram_ctrl;
  logic        clk, rst_n;
  logic        req_valid, req_ready, req_we;
  logic [23:0] req_addr;
  logic [3:0]  req_wdata, rsp_rdata, dram_dq_o, dram_dq_i;
  logic        rsp_valid, ref_req, ref_gnt;
  logic [12:0] dram_addr;
  logic        dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;

  int n_chk = 0, n_fail = 0;
  bit rst_done = 0;

  fpm_dram_ctrl #(.CLK_NS(20), .RAS_MAX_NS(1000)) i_fpm_dram_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ref_req(ref_req),
    .ref_gnt(ref_gnt), .dram_addr(dram_addr), .dram_ras_n(dram_ras_n),
    .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
    .dram_dq_o(dram_dq_o), .dram_dq_oe(dram_dq_oe), .dram_dq_i(dram_dq_i)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // ---------------- behavioural memory model ----------------
  logic [3:0]  mem [int unsigned];
  realtime t_rasf = -1000, t_rasr = -1000, t_casf = -1000, t_casr = -1000;
  realtime t_addr = -1000, t_wef = -1000;
  int v_rcd = 0, v_rah = 0, v_we = 0, v_pg = 0, v_rp = 0, v_rc = 0, v_open = 0, n_rise = 0;
  logic [12:0] m_row = '0;
  logic [10:0] m_col = '0;
  logic [1:0]  m_colhi = '0;

  function automatic logic [3:0] fill(input logic [23:0] k);
    return k[3:0] ^ k[11:8] ^ k[19:16] ^ 4'h5;
  endfunction

  function automatic logic [3:0] rd(input logic [23:0] k);
    if (mem.exists(int'(k))) return mem[int'(k)];
    return fill(k);
  endfunction

  always @(negedge dram_ras_n) begin
    if (rst_done) begin
      if ($realtime - t_rasr < 40) v_rp++;
      if ($realtime - t_rasf < 110) v_rc++;
    end
    t_rasf = $realtime;
    #1 m_row = dram_addr;
  end

  always @(posedge dram_ras_n) begin
    if (rst_done) begin
      if ($realtime - t_rasf > 1000) v_open++;
      n_rise++;
    end
    t_rasr = $realtime;
  end

  always @(dram_addr) begin
    if (rst_done && !dram_ras_n && dram_cas_n &&
        ($realtime - t_rasf > 0) && ($realtime - t_rasf < 10)) v_rah++;
    if (rst_done && !dram_cas_n) v_pg++;
    t_addr = $realtime;
  end

  always @(negedge dram_we_n) t_wef = $realtime;

  always @(negedge dram_cas_n) begin
    if (rst_done) begin
      if (dram_ras_n || ($realtime - t_rasf < 20)) v_rcd++;
      if ($realtime - t_casr < 10) v_pg++;
      if ($realtime - t_casf < 40) v_pg++;
    end
    m_col   = dram_addr[10:0];
    m_colhi = dram_addr[12:11];
    if (!dram_we_n) begin
      if (!(t_wef < $realtime) || !dram_oe_n || !dram_dq_oe) v_we++;
      mem[int'({m_row, m_col})] = dram_dq_o;
    end
    t_casf = $realtime;
  end

  always @(posedge dram_cas_n) begin
    if (rst_done && ($realtime - t_casf < 15)) v_pg++;
    t_casr = $realtime;
  end

  always @(negedge clk) begin
    realtime ts;
    ts = $realtime + 10;
    if (rst_done && !dram_cas_n && !dram_we_n && (!dram_dq_oe || !dram_oe_n)) v_we++;
    if (!dram_cas_n && !dram_oe_n && dram_we_n &&
        (ts - t_rasf >= 60) && (ts - t_casf >= 15) && (ts - t_addr >= 30))
      dram_dq_i <= rd({m_row, m_col});
    else
      dram_dq_i <= ~rd({m_row, m_col});
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string rq, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic host_req(input logic we, input logic [23:0] a, input logic [3:0] d);
    req_we = we; req_addr = a; req_wdata = d; req_valid = 1'b1;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic host_read(input logic [23:0] a, output logic [3:0] d);
    host_req(1'b0, a, 4'h0);
    while (!rsp_valid) @(negedge clk);
    d = rsp_rdata;
    @(negedge clk);
    check(rsp_valid == 1'b0, "R3", "response lasts one cycle", rsp_valid, 0);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    logic [7:0] s;
    s = {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe, ref_gnt, req_ready, rsp_valid};
    check(s == 8'hF2, "R1", "idle outputs after reset", s, 8'hF2);
  endtask

  task automatic t_first_read();
    logic [3:0]  d;
    logic [23:0] a;
    a = {13'h1ABC, 11'h2F3};
    host_read(a, d);
    check(m_row == 13'h1ABC, "R2", "row on address pins", m_row, 13'h1ABC);
    check(m_col == 11'h2F3, "R2", "column on address pins", m_col, 11'h2F3);
    check(m_colhi == 2'b00, "R2", "row-only pins zero in column", m_colhi, 0);
    check(v_rcd == 0 && v_rah == 0, "R2", "row hold / CAS delay violations", v_rcd + v_rah, 0);
    check(d == fill(a), "R3", "read data after access times", d, fill(a));
  endtask

  task automatic t_write_hit();
    int r0;
    logic [3:0] d;
    r0 = n_rise;
    for (int i = 0; i < 3; i++) host_req(1'b1, {13'h1ABC, 11'(i + 8)}, 4'(4'hA + i));
    for (int i = 0; i < 3; i++) begin
      host_read({13'h1ABC, 11'(i + 8)}, d);
      check(d == 4'(4'hA + i), "R6", "written nibble read back", d, 4'(4'hA + i));
    end
    check(n_rise == r0, "R4", "RAS stays low over page hits", n_rise - r0, 0);
    check(v_we == 0, "R6", "early-write / bus drive violations", v_we, 0);
    check(v_pg == 0, "R7", "page CAS width/cycle violations", v_pg, 0);
  endtask

  task automatic t_row_miss();
    int r0;
    logic [3:0] d;
    r0 = n_rise;
    host_read({13'h0042, 11'h007}, d);
    check(n_rise == r0 + 1, "R5", "row closed on miss", n_rise - r0, 1);
    check(m_row == 13'h0042, "R5", "new row opened", m_row, 13'h0042);
    check(d == fill({13'h0042, 11'h007}), "R3", "read after miss", d, fill({13'h0042, 11'h007}));
    host_read({13'h1ABC, 11'd9}, d);
    check(d == 4'hB, "R5", "old row data after reopen", d, 4'hB);
    check(v_rp == 0, "R5", "precharge violations", v_rp, 0);
    check(v_rc == 0, "R10", "random cycle violations", v_rc, 0);
  endtask

  task automatic t_max_open();
    int r0, bad;
    logic [3:0] d;
    r0 = n_rise; bad = 0;
    for (int i = 0; i < 24; i++) begin
      host_read({13'h0777, 11'(i)}, d);
      if (d != fill({13'h0777, 11'(i)})) bad++;
    end
    check(bad == 0, "R8", "reads across forced close", bad, 0);
    check(n_rise >= r0 + 2, "R8", "row closed under continuous hits", n_rise - r0, 2);
    check(v_open == 0, "R8", "RAS-low limit violations", v_open, 0);
  endtask

  task automatic t_refresh();
    logic [3:0] d;
    realtime t_rel;
    int w, bad;
    host_read({13'h0100, 11'h001}, d);
    ref_req = 1'b1;
    w = 0;
    while (!ref_gnt && w < 50) begin @(negedge clk); w++; end
    check(ref_gnt == 1'b1, "R9", "grant after refresh request", ref_gnt, 1);
    bad = 0;
    req_we = 1'b0; req_addr = {13'h0100, 11'h002}; req_valid = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (!dram_ras_n || !dram_cas_n || req_ready) bad++;
    end
    check(bad == 0, "R9", "bus quiet during grant", bad, 0);
    req_valid = 1'b0;
    ref_req = 1'b0;
    @(negedge clk);
    t_rel = $realtime - 10;
    check(ref_gnt == 1'b0, "R9", "grant released", ref_gnt, 0);
    host_read({13'h0100, 11'h003}, d);
    check((t_rasf - t_rel) >= 40, "R9", "precharge after release (ns)",
          int'(t_rasf - t_rel), 40);
    check(d == fill({13'h0100, 11'h003}), "R9", "read after refresh", d,
          fill({13'h0100, 11'h003}));
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_fail++;
    $display("FAIL R1 watchdog: actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_we = 1'b0; req_addr = '0;
    req_wdata = '0; ref_req = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rst_done = 1;
    t_reset();
    t_first_read();
    t_write_hit();
    t_row_miss();
    t_max_open();
    t_refresh();
    repeat (3) @(negedge clk);
    summary();
    $finish;
  end
endmodule